// File: doc/BRIEF.md
# Dual-Order Burst Address Generator

This block produces the word address for a four-beat wrap-around burst. When a burst starts, a load strobe captures a full starting address. The upper bits are kept in a register. The two lowest bits seed a two-bit burst position. The block then walks through the four beats of the burst under control of an active-low advance input. When advance is held high, the burst is suspended and the current address is held.

A single order-select input chooses between two beat orders. The linear order adds the beat number to the start modulo four. The interleaved order XORs the start with the beat number. The output is the registered upper bits joined with the two mapped low bits, so the order-select input acts on the beat that is current.

The reset input is asynchronous and active low. Its release is synchronised inside the block. The integrating level is expected to tie the order-select input high when it is not driven, so that an undriven select gives the interleaved order.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low, `addr_out` is all zeros. After `rst_n` rises, the block ignores `load` and `adv_n` for two clock edges (the reset release is synchronised), and `addr_out` stays zero.
- R2: A clock rise with `load` high captures `start_addr` whole. From the next cycle `addr_out` equals the captured address, and the beat number restarts at 0.
- R3: With `order_sel` = 0 (linear), each accepted advance adds 1 modulo 4 to `addr_out[1:0]`. For example, a start of 2 gives 2, 3, 0, 1.
- R4: With `order_sel` = 1 (interleaved), `addr_out[1:0]` at beat n equals the start's two low bits XOR n. For example, a start of 1 gives 1, 0, 3, 2 and a start of 2 gives 2, 3, 0, 1.
- R5: A clock rise with `load` low and `adv_n` high leaves `addr_out` unchanged (the burst is suspended).
- R6: When `load` is high and `adv_n` is low on the same clock rise, the load wins. The next `addr_out` is the new start address at beat 0.
- R7: `addr_out[ADDR_W-1:2]` changes only on a load. Advances and suspends never alter it.
- R8: After four accepted advances, `addr_out` returns to the starting address in either order.
- R9: A load in the middle of a burst drops the old burst position. The following advances start again from beat 0 of the new address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| load | input | 1 | High: capture `start_addr` and begin a new burst |
| start_addr | input | ADDR_W | Starting word address of a burst |
| adv_n | input | 1 | Low: step to the next beat; high: suspend the burst |
| order_sel | input | 1 | 1 = interleaved (XOR) order, 0 = linear (modulo-4 add) order |
| addr_out | output | ADDR_W | Current address: registered upper bits and mapped low bits |

## Verification
The load strobe and the advance input can both act on the same clock rise. The bench provokes this by raising `load` with `adv_n` low, both at the start of a burst and in the middle of one. A behavioural model that gives the load priority then decides the expected address, which must be the new start at beat 0 with no extra step. The same model, stepped on every edge, also judges each plain advance and suspend in both orders.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int BEAT_W = 2;
  typedef logic [BEAT_W-1:0] beat_t;

  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_INTLV  = 1'b1
  } order_e;

  // Low address bits for beat n of a burst that started at s.
  function automatic beat_t map_beat(order_e ord, beat_t s, beat_t n);
    beat_t res;
    if (ord == ORD_INTLV) res = s ^ n;
    else                  res = beat_t'(s + n);
    return res;
  endfunction
endpackage

// File: rtl/burst_rst_sync.sv
module burst_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  logic  adv_n,
  output beat_t beat
);
  beat_t beat_q, beat_d;
  logic  beat_en;

  always_comb begin
    beat_en = load | ~adv_n;
    if (load) beat_d = '0;
    else      beat_d = beat_q + beat_t'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       beat_q <= '0;
    else if (beat_en) beat_q <= beat_d;
  end

  assign beat = beat_q;
endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg
  import burst_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] start_addr,
  output logic [ADDR_W-1:BEAT_W] upper,
  output beat_t             start_low
);
  localparam int UPPER_W = ADDR_W - BEAT_W;

  logic [UPPER_W-1:0] upper_q, upper_d;
  beat_t              low_q, low_d;

  always_comb begin
    upper_d = start_addr[ADDR_W-1:BEAT_W];
    low_d   = start_addr[BEAT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper_q <= '0;
      low_q   <= '0;
    end else if (load) begin
      upper_q <= upper_d;
      low_q   <= low_d;
    end
  end

  assign upper     = upper_q;
  assign start_low = low_q;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              adv_n,
  input  logic              order_sel,
  output logic [ADDR_W-1:0] addr_out
);
  logic                   rst_q_n;
  beat_t                  beat;
  beat_t                  start_low;
  logic [ADDR_W-1:BEAT_W] upper;
  beat_t                  low_out;

  burst_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .load       (load),
    .start_addr (start_addr),
    .upper      (upper),
    .start_low  (start_low)
  );

  burst_beat_ctr u_beat (
    .clk   (clk),
    .rst_n (rst_q_n),
    .load  (load),
    .adv_n (adv_n),
    .beat  (beat)
  );

  always_comb begin
    low_out = map_beat(order_e'(order_sel), start_low, beat);
  end

  assign addr_out = {upper, low_out};
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              load,
  input logic [ADDR_W-1:0] start_addr,
  input logic              adv_n,
  input logic              order_sel,
  input logic [ADDR_W-1:0] addr_out
);
  logic armed;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) armed <= 1'b0;
    else             armed <= 1'b1;
  end

  // R2 and R6: a load wins and is captured whole
  p_load_capture_r2: assert property (@(posedge clk) disable iff (!armed)
    load |=> ($stable(order_sel) -> addr_out == $past(start_addr)));

  // R3: a linear advance adds one to the low bits
  p_linear_step_r3: assert property (@(posedge clk) disable iff (!armed)
    (!load && !adv_n && !order_sel) |=>
      (order_sel || addr_out[1:0] == $past(addr_out[1:0]) + 2'd1));

  // R5: a suspend holds the address
  p_suspend_hold_r5: assert property (@(posedge clk) disable iff (!armed)
    (!load && adv_n) |=> (!$stable(order_sel) || $stable(addr_out)));

  // R7: upper bits move only on a load
  p_upper_const_r7: assert property (@(posedge clk) disable iff (!armed)
    !load |=> $stable(addr_out[ADDR_W-1:2]));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_q_n),
  .load       (load),
  .start_addr (start_addr),
  .adv_n      (adv_n),
  .order_sel  (order_sel),
  .addr_out   (addr_out)
);

// File: tb/tb_burst_addr_gen.sv
`timescale 1ns/1ps
module tb_burst_addr_gen;
  localparam int ADDR_W = 17;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              load;
  logic [ADDR_W-1:0] start_addr;
  logic              adv_n;
  logic              order_sel;
  logic [ADDR_W-1:0] addr_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // behavioural reference
  int ref_up = 0, ref_st = 0, ref_bt = 0;

  always #2 clk = ~clk;

  burst_addr_gen #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .load(load), .start_addr(start_addr),
    .adv_n(adv_n), .order_sel(order_sel), .addr_out(addr_out)
  );

  function automatic int expect_addr();
    int low;
    if (order_sel) low = ref_st ^ ref_bt;
    else           low = (ref_st + ref_bt) % 4;
    return ref_up * 4 + low;
  endfunction

  task automatic check(string tag, int exp_v);
    n_tests++;
    if (int'(addr_out) != exp_v) begin
      n_fail++;
      $display("FAIL %s: addr_out=0x%0h expected 0x%0h", tag, addr_out, exp_v);
    end
  endtask

  // apply one cycle of stimulus, advance the model, compare at the falling edge
  task automatic step(input bit ld, input int a, input bit advn, input bit ord, input string tag);
    load = ld; start_addr = ADDR_W'(a); adv_n = advn; order_sel = ord;
    @(posedge clk);
    if (ld) begin
      ref_up = a / 4; ref_st = a % 4; ref_bt = 0;
    end else if (!advn) begin
      ref_bt = (ref_bt + 1) % 4;
    end
    @(negedge clk);
    check(tag, expect_addr());
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int base;
    rst_n = 1'b0; load = 1'b0; start_addr = '0; adv_n = 1'b1; order_sel = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 in reset", 0);
    rst_n = 1'b1;
    // loads and advances during the synchronised release are ignored
    load = 1'b1; start_addr = 17'h1ABCD; adv_n = 1'b0;
    @(negedge clk);
    check("R1 release edge 1", 0);
    load = 1'b0;
    @(negedge clk);
    check("R1 release edge 2", 0);
    adv_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle", 0);

    // linear burst from start 2, full wrap
    base = 'h1ABC6;
    step(1, base, 1, 0, "R2 load linear");
    step(0, 0, 0, 0, "R3 linear beat1");
    step(0, 0, 0, 0, "R3 linear beat2");
    step(0, 0, 0, 0, "R3 linear beat3 R7");
    step(0, 0, 0, 0, "R8 linear wrap");
    check("R8 linear back at start", base);
    step(0, 0, 1, 0, "R5 suspend");
    step(0, 0, 1, 0, "R5 suspend again");
    step(0, 0, 0, 0, "R3 after suspend");

    // interleaved bursts from all four starts
    for (int s = 0; s < 4; s++) begin
      step(1, 'h0F3C0 + s, 1, 1, "R2 load interleaved");
      for (int b = 0; b < 4; b++) begin
        step(0, 'h1FFFF, 0, 1, "R4 interleaved beat");
        if (b == 1) step(0, 0, 1, 1, "R5 interleaved suspend");
      end
      check("R8 interleaved wrap", 'h0F3C0 + s);
    end

    // load and advance together
    step(0, 0, 0, 1, "R4 pre");
    step(1, 'h15555, 0, 1, "R6 load over advance");
    check("R6 exact start", 'h15555);
    step(0, 0, 0, 1, "R4 after R6");
    step(0, 0, 0, 1, "R4 after R6 b2");
    // load mid-burst restarts at beat 0, combined with advance
    step(1, 'h0AAA3, 0, 0, "R9 mid-burst load");
    check("R9 restart", 'h0AAA3);
    step(0, 0, 0, 0, "R9 beat1 linear");
    check("R9 linear 3->0", 'h0AAA0);
    step(0, 0, 0, 0, "R9 beat2 linear R7");
    step(0, 'h1FFFF, 1, 0, "R7 upper held");

    // reset mid-run returns to zero
    rst_n = 1'b0;
    #1;
    check("R1 async reset", 0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule